// File: doc/BRIEF.md
# Dual-Clock FIFO with Synchronized Status Flags

This block is a 64-word, 36-bit queue that joins two unrelated clock domains. A producer pushes words on the write clock and a consumer pops them on the read clock. Words leave in the order they entered. Each side keeps its own binary pointer and passes a Gray-coded copy of it to the other side.

The block drives four active-low status flags. On the write side these are full and almost-full. On the read side they are empty and almost-empty. A flag goes low in the same edge as the local operation that crosses its threshold. It goes high only after the other side's pointer has crossed the clock boundary, on the second rising edge of its own clock after that operation.

The almost threshold X is taken from four presets (4, 8, 16, 32). The preset is selected by a 2-bit input that is sampled while reset is held.

Each side is a three-state machine. The write side has `W_OPEN`, `W_NEAR` and `W_FULL`. The read side has `R_EMPTY`, `R_THIN` and `R_READY`. On every edge the next state is chosen from the level projected after that edge's operation. A climb transition moves toward `W_FULL` or `R_READY`, and a drain transition moves back. Any state may jump to any other when the level changes by several words between edges.

Top module: `xfifo_dual`

## Requirements
- R1: Accepted words appear on `rd_data` in the order they were written, with all 36 bits intact. Up to 64 words can be held at once.
- R2: `full_n` is 0 exactly when 64 words are held. It goes to 0 at the write-clock edge that stores the 64th word. A write attempted while `full_n` is 0 changes nothing.
- R3: A read attempted while `empty_n` is 0 is ignored, and `rd_data` keeps its previous value. An accepted read places the word on `rd_data` at that read-clock edge.
- R4: `empty_n` is 0 at 0 words and 1 from 1 word upward. It falls at the read edge that takes the last word. After a write into an empty queue, it rises on the second rising `rd_clk` edge following that write.
- R5: `aempty_n` is 0 at X or fewer words and 1 at X+1 or more. It falls at the read edge that brings the level down to X. After the write that lifts the level to X+1, it rises on the second rising `rd_clk` edge.
- R6: `afull_n` is 0 at 64−X or more words and 1 at 63−X or fewer. It falls at the write edge that reaches 64−X.
- R7: After a read frees a slot in a full queue, `full_n` stays 0 through the first rising `wr_clk` edge and becomes 1 on the second. A write on the following edge is accepted.
- R8: After the read that lowers the level to 63−X, `afull_n` becomes 1 on the second rising `wr_clk` edge.
- R9: While `rst_n` is 0 the queue is emptied and the flags settle to `full_n`=1, `afull_n`=1, `empty_n`=0 and `aempty_n`=0, with `rd_data`=0. `ofs_sel` values 0, 1, 2 and 3 give X = 4, 8, 16 and 32.
- R10: Writes and reads that overlap in time, including across the full and empty boundaries, all take effect without loss or duplication.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Active-low reset, sampled synchronously in both domains |
| ofs_sel | input | 2 | Threshold preset select, captured while reset is low |
| wr_clk | input | 1 | Write-domain clock |
| wr_en | input | 1 | Write request |
| wr_data | input | 36 | Word to store |
| full_n | output | 1 | Low when no slot is free (write domain) |
| afull_n | output | 1 | Low at 64−X words or more (write domain) |
| rd_clk | input | 1 | Read-domain clock |
| rd_en | input | 1 | Read request |
| rd_data | output | 36 | Last word read |
| empty_n | output | 1 | Low when no word is held (read domain) |
| aempty_n | output | 1 | Low at X words or fewer (read domain) |

## Verification
A push and a pop can land in the same instant of wall time. They then move the level in opposite directions while each side still sees a stale copy of the other side's pointer. The worst case is a producer retrying against a full queue while the consumer frees a slot, and the mirror case at empty.

Both cases are provoked by a phase where independent writer and reader threads run concurrently, with gap patterns that make the queue fill to full and later drain to empty. The clock periods never align, so these overlaps occur at every phase offset. The scoreboard judges the run on order and completeness. A settled check then compares all four flags with the reference level.

// File: rtl/xfifo_pkg.sv
`timescale 1ns/1ps
package xfifo_pkg;

    // Write-side classification of the projected fill level.
    typedef enum logic [1:0] {
        W_OPEN = 2'd0,
        W_NEAR = 2'd1,
        W_FULL = 2'd2
    } wr_state_e;

    // Read-side classification of the projected fill level.
    typedef enum logic [1:0] {
        R_EMPTY = 2'd0,
        R_THIN  = 2'd1,
        R_READY = 2'd2
    } rd_state_e;

    // Threshold preset table: 4, 8, 16, 32.
    function automatic int unsigned preset_ofs(input logic [1:0] sel);
        return 32'd4 << sel;
    endfunction

endpackage

// File: rtl/xfifo_ptr_capture.sv
`timescale 1ns/1ps
// Captures a Gray pointer from the far domain and decodes it to binary.
// The flag state register that consumes bin_out acts as the second stage.
module xfifo_ptr_capture #(
    parameter int W = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] gray_in,
    output logic [W-1:0] bin_out
);
    logic [W-1:0] cap_q;

    always_ff @(posedge clk) begin
        if (!rst_n) cap_q <= '0;
        else        cap_q <= gray_in;
    end

    always_comb begin
        for (int i = 0; i < W; i++) begin
            bin_out[i] = ^(cap_q >> i);
        end
    end

endmodule

// File: rtl/xfifo_wr_side.sv
`timescale 1ns/1ps
module xfifo_wr_side
    import xfifo_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        ofs_sel,
    input  logic              wr_en,
    input  logic [ADDR_W:0]   rbin_cap,
    output logic              push,
    output logic [ADDR_W-1:0] waddr,
    output logic [ADDR_W:0]   wgray,
    output logic              full_n,
    output logic              afull_n
);
    localparam int PW = ADDR_W + 1;
    localparam logic [PW-1:0] DEPTH_P = PW'(1 << ADDR_W);

    wr_state_e     st, st_nxt;
    logic [PW-1:0] wbin, wbin_nxt, lvl_nxt, ofs_q;

    // Threshold captured while reset is held.
    always_ff @(posedge clk) begin
        if (!rst_n) ofs_q <= PW'(preset_ofs(ofs_sel));
    end

    assign push     = wr_en && (st != W_FULL);
    assign wbin_nxt = wbin + PW'(push);
    assign lvl_nxt  = wbin_nxt - rbin_cap;
    assign waddr    = wbin[ADDR_W-1:0];

    // Next state from the level projected after this edge.
    always_comb begin
        if (lvl_nxt == DEPTH_P)              st_nxt = W_FULL;
        else if (lvl_nxt >= DEPTH_P - ofs_q) st_nxt = W_NEAR;
        else                                 st_nxt = W_OPEN;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st    <= W_OPEN;
            wbin  <= '0;
            wgray <= '0;
        end else begin
            st    <= st_nxt;
            wbin  <= wbin_nxt;
            wgray <= wbin_nxt ^ (wbin_nxt >> 1);
        end
    end

    always_comb begin
        unique case (st)
            W_OPEN:  begin full_n = 1'b1; afull_n = 1'b1; end
            W_NEAR:  begin full_n = 1'b1; afull_n = 1'b0; end
            W_FULL:  begin full_n = 1'b0; afull_n = 1'b0; end
            default: begin full_n = 1'b1; afull_n = 1'b1; end
        endcase
    end

    // R2: a refused write leaves the published pointer unchanged
    a_r2_full_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!full_n && wr_en) |=> $stable(wgray));

    // R2: the level seen by the write side never exceeds the depth
    a_r2_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (wbin - rbin_cap) <= DEPTH_P);

endmodule

// File: rtl/xfifo_rd_side.sv
`timescale 1ns/1ps
module xfifo_rd_side
    import xfifo_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        ofs_sel,
    input  logic              rd_en,
    input  logic [ADDR_W:0]   wbin_cap,
    output logic              pop,
    output logic [ADDR_W-1:0] raddr,
    output logic [ADDR_W:0]   rgray,
    output logic              empty_n,
    output logic              aempty_n
);
    localparam int PW = ADDR_W + 1;
    localparam logic [PW-1:0] DEPTH_P = PW'(1 << ADDR_W);

    rd_state_e     st, st_nxt;
    logic [PW-1:0] rbin, rbin_nxt, lvl_nxt, ofs_q;

    always_ff @(posedge clk) begin
        if (!rst_n) ofs_q <= PW'(preset_ofs(ofs_sel));
    end

    assign pop      = rd_en && (st != R_EMPTY);
    assign rbin_nxt = rbin + PW'(pop);
    assign lvl_nxt  = wbin_cap - rbin_nxt;
    assign raddr    = rbin[ADDR_W-1:0];

    always_comb begin
        if (lvl_nxt == '0)        st_nxt = R_EMPTY;
        else if (lvl_nxt <= ofs_q) st_nxt = R_THIN;
        else                       st_nxt = R_READY;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st    <= R_EMPTY;
            rbin  <= '0;
            rgray <= '0;
        end else begin
            st    <= st_nxt;
            rbin  <= rbin_nxt;
            rgray <= rbin_nxt ^ (rbin_nxt >> 1);
        end
    end

    always_comb begin
        unique case (st)
            R_EMPTY: begin empty_n = 1'b0; aempty_n = 1'b0; end
            R_THIN:  begin empty_n = 1'b1; aempty_n = 1'b0; end
            R_READY: begin empty_n = 1'b1; aempty_n = 1'b1; end
            default: begin empty_n = 1'b0; aempty_n = 1'b0; end
        endcase
    end

    // R3: the read side never sees more words than the depth (no underflow wrap)
    a_r3_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (wbin_cap - rbin) <= DEPTH_P);

    // R3: the read pointer advances by at most one word per edge
    a_r3_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (rbin - $past(rbin)) <= PW'(1));

endmodule

// File: rtl/xfifo_ram.sv
`timescale 1ns/1ps
module xfifo_ram #(
    parameter int DATA_W = 36,
    parameter int ADDR_W = 6
) (
    input  logic              wclk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              rclk,
    input  logic              rrst_n,
    input  logic              re,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge wclk) begin
        if (we) mem[waddr] <= wdata;
    end

    always_ff @(posedge rclk) begin
        if (!rrst_n)  rdata <= '0;
        else if (re)  rdata <= mem[raddr];
    end

endmodule

// File: rtl/xfifo_dual.sv
`timescale 1ns/1ps
module xfifo_dual
    import xfifo_pkg::*;
#(
    parameter int DATA_W = 36,
    parameter int ADDR_W = 6
) (
    input  logic              rst_n,
    input  logic [1:0]        ofs_sel,
    input  logic              wr_clk,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic              full_n,
    output logic              afull_n,
    input  logic              rd_clk,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              empty_n,
    output logic              aempty_n
);
    localparam int PTR_W = ADDR_W + 1;

    logic              push, pop;
    logic [ADDR_W-1:0] waddr, raddr;
    logic [PTR_W-1:0]  wgray, rgray, wbin_cap, rbin_cap;

    xfifo_wr_side #(.ADDR_W(ADDR_W)) u_wr (
        .clk(wr_clk), .rst_n(rst_n), .ofs_sel(ofs_sel), .wr_en(wr_en),
        .rbin_cap(rbin_cap), .push(push), .waddr(waddr), .wgray(wgray),
        .full_n(full_n), .afull_n(afull_n)
    );

    xfifo_rd_side #(.ADDR_W(ADDR_W)) u_rd (
        .clk(rd_clk), .rst_n(rst_n), .ofs_sel(ofs_sel), .rd_en(rd_en),
        .wbin_cap(wbin_cap), .pop(pop), .raddr(raddr), .rgray(rgray),
        .empty_n(empty_n), .aempty_n(aempty_n)
    );

    xfifo_ptr_capture #(.W(PTR_W)) u_w2r (
        .clk(rd_clk), .rst_n(rst_n), .gray_in(wgray), .bin_out(wbin_cap)
    );

    xfifo_ptr_capture #(.W(PTR_W)) u_r2w (
        .clk(wr_clk), .rst_n(rst_n), .gray_in(rgray), .bin_out(rbin_cap)
    );

    xfifo_ram #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ram (
        .wclk(wr_clk), .we(push), .waddr(waddr), .wdata(wr_data),
        .rclk(rd_clk), .rrst_n(rst_n), .re(pop), .raddr(raddr), .rdata(rd_data)
    );

    // R3: a read refused at empty leaves the output word untouched
    a_r3_empty_hold: assert property (@(posedge rd_clk) disable iff (!rst_n)
        (!empty_n && rd_en) |=> $stable(rd_data));

endmodule

// File: tb/test_xfifo_dual.sv
`timescale 1ns/1ps
module test_xfifo_dual;
    localparam int DW    = 36;
    localparam int DEPTH = 64;

    logic          rst_n   = 1'b0;
    logic [1:0]    ofs_sel = 2'd1;
    logic          wr_clk  = 1'b0;
    logic          rd_clk  = 1'b0;
    logic          wr_en   = 1'b0;
    logic          rd_en   = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic [DW-1:0] rd_data;
    logic          full_n, afull_n, empty_n, aempty_n;

    int            checks = 0;
    int            errors = 0;
    int            occ    = 0;
    int            xval   = 8;
    int            serial = 0;
    bit            finished = 1'b0;
    logic [DW-1:0] sb_q[$];
    logic [DW-1:0] last_rd = '0;

    xfifo_dual i_xfifo_dual (
        .rst_n(rst_n), .ofs_sel(ofs_sel),
        .wr_clk(wr_clk), .wr_en(wr_en), .wr_data(wr_data),
        .full_n(full_n), .afull_n(afull_n),
        .rd_clk(rd_clk), .rd_en(rd_en), .rd_data(rd_data),
        .empty_n(empty_n), .aempty_n(aempty_n)
    );

    // 50 MHz write clock; read clock on an unrelated 27.4 ns period whose edges never align
    always #10   wr_clk = ~wr_clk;
    always #13.7 rd_clk = ~rd_clk;

    task automatic tally(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic flag_of(input int which);
        case (which)
            0:       return full_n;
            1:       return afull_n;
            2:       return empty_n;
            default: return aempty_n;
        endcase
    endfunction

    task automatic fresh(output logic [DW-1:0] d);
        serial++;
        d = {4'(serial) ^ 4'hA, 32'(serial) * 32'h9E3779B1};
    endtask

    // Scoreboard pop: compare the word just read against the oldest pushed word
    task automatic pop_cmp();
        logic [DW-1:0] exp;
        exp = (sb_q.size() > 0) ? sb_q.pop_front() : '0;
        occ--;
        tally(rd_data == exp, "R1", "read word order", 64'(rd_data), 64'(exp));
        last_rd = rd_data;
    endtask

    task automatic settle(input string req);
        repeat (4) @(posedge wr_clk);
        repeat (4) @(posedge rd_clk);
        #1;
        tally(full_n   == (occ != DEPTH),        req, "full_n settled",   64'(full_n),   64'(occ != DEPTH));
        tally(afull_n  == (occ <  DEPTH - xval), req, "afull_n settled",  64'(afull_n),  64'(occ < DEPTH - xval));
        tally(empty_n  == (occ != 0),            req, "empty_n settled",  64'(empty_n),  64'(occ != 0));
        tally(aempty_n == (occ >  xval),         req, "aempty_n settled", 64'(aempty_n), 64'(occ > xval));
    endtask

    task automatic wr_word(input logic [DW-1:0] d, output bit acc);
        @(negedge wr_clk);
        acc = full_n; wr_en = 1'b1; wr_data = d;
        @(posedge wr_clk);
        #1 wr_en = 1'b0;
        if (acc) begin sb_q.push_back(d); occ++; end
    endtask

    task automatic rd_word(output bit acc);
        @(negedge rd_clk);
        acc = empty_n; rd_en = 1'b1;
        @(posedge rd_clk);
        #1 rd_en = 1'b0;
        if (acc) pop_cmp();
        else tally(rd_data == last_rd, "R3", "rd_data held on empty read", 64'(rd_data), 64'(last_rd));
    endtask

    // Write one word, then watch a read-side flag over the next two rd_clk edges
    task automatic wr_watch(input int which, input string req);
        logic [DW-1:0] d;
        bit acc;
        fresh(d);
        @(negedge wr_clk);
        acc = full_n; wr_en = 1'b1; wr_data = d;
        @(posedge wr_clk);
        fork begin #1 wr_en = 1'b0; end join_none
        if (acc) begin sb_q.push_back(d); occ++; end
        @(posedge rd_clk); #1;
        tally(flag_of(which) == 1'b0, req, "flag after first rd edge", 64'(flag_of(which)), 64'd0);
        @(posedge rd_clk); #1;
        tally(flag_of(which) == 1'b1, req, "flag after second rd edge", 64'(flag_of(which)), 64'd1);
    endtask

    // Read one word, then watch a write-side flag over the next two wr_clk edges
    task automatic rd_watch(input int which, input string req);
        bit acc;
        @(negedge rd_clk);
        acc = empty_n; rd_en = 1'b1;
        @(posedge rd_clk);
        fork begin #1 rd_en = 1'b0; end join_none
        @(posedge wr_clk); #1;
        tally(flag_of(which) == 1'b0, req, "flag after first wr edge", 64'(flag_of(which)), 64'd0);
        @(posedge wr_clk); #1;
        tally(flag_of(which) == 1'b1, req, "flag after second wr edge", 64'(flag_of(which)), 64'd1);
        if (acc) pop_cmp();
    endtask

    task automatic do_reset(input logic [1:0] s);
        rst_n = 1'b0; ofs_sel = s;
        repeat (4) @(posedge wr_clk);
        repeat (4) @(posedge rd_clk);
        @(negedge wr_clk);
        rst_n = 1'b1;
        repeat (2) @(posedge rd_clk);
        #1;
        sb_q.delete(); occ = 0; last_rd = '0; xval = 4 << s;
    endtask

    initial begin
        logic [DW-1:0] d;
        bit ok;

        do_reset(2'd1);
        // R9: reset state
        tally(full_n == 1'b1,   "R9", "reset full_n",   64'(full_n),   64'd1);
        tally(afull_n == 1'b1,  "R9", "reset afull_n",  64'(afull_n),  64'd1);
        tally(empty_n == 1'b0,  "R9", "reset empty_n",  64'(empty_n),  64'd0);
        tally(aempty_n == 1'b0, "R9", "reset aempty_n", 64'(aempty_n), 64'd0);
        tally(rd_data == '0,    "R9", "reset rd_data",  64'(rd_data),  64'd0);

        rd_word(ok);                                   // R3: read on empty ignored
        tally(ok == 1'b0, "R3", "empty read refused", 64'(ok), 64'd0);

        wr_watch(2, "R4");                             // R4: empty_n rise latency
        while (occ < 8) begin fresh(d); wr_word(d, ok); end
        settle("R5");
        wr_watch(3, "R5");                             // R5: aempty_n rise at X+1

        while (occ < 55) begin fresh(d); wr_word(d, ok); end
        settle("R6");
        fresh(d); wr_word(d, ok);
        tally(afull_n == 1'b0, "R6", "afull_n falls at 64-X", 64'(afull_n), 64'd0);
        while (occ < 63) begin fresh(d); wr_word(d, ok); end
        tally(full_n == 1'b1, "R2", "full_n at 63", 64'(full_n), 64'd1);
        fresh(d); wr_word(d, ok);
        tally(full_n == 1'b0, "R2", "full_n falls at 64", 64'(full_n), 64'd0);
        for (int k = 0; k < 3; k++) begin
            fresh(d); wr_word(d, ok);
            tally(ok == 1'b0, "R2", "write refused while full", 64'(ok), 64'd0);
        end
        settle("R2");

        rd_watch(0, "R7");                             // R7: full_n rise latency
        fresh(d); wr_word(d, ok);
        tally(ok == 1'b1,      "R7", "write accepted after release", 64'(ok), 64'd1);
        tally(full_n == 1'b0,  "R7", "full again after refill",      64'(full_n), 64'd0);

        while (occ > 56) rd_word(ok);
        settle("R8");
        rd_watch(1, "R8");                             // R8: afull_n rise at 63-X

        while (occ > 8) rd_word(ok);
        tally(aempty_n == 1'b0, "R5", "aempty_n falls at X", 64'(aempty_n), 64'd0);
        while (occ > 0) rd_word(ok);
        tally(empty_n == 1'b0, "R4", "empty_n falls at 0", 64'(empty_n), 64'd0);
        rd_word(ok);
        tally(ok == 1'b0, "R3", "empty read refused again", 64'(ok), 64'd0);
        settle("R4");

        // R10: concurrent producer and consumer crossing full and empty
        fork
            begin : writer
                for (int i = 0; i < 150; i++) begin
                    logic [DW-1:0] wd;
                    bit wok;
                    fresh(wd);
                    wok = 1'b0;
                    while (!wok) wr_word(wd, wok);
                    if (i >= 90) repeat (3) @(negedge wr_clk);
                end
            end
            begin : reader
                int got;
                bit rok;
                got = 0;
                while (got < 150) begin
                    rd_word(rok);
                    if (rok) got++;
                    if (got < 70) repeat (2) @(negedge rd_clk);
                end
            end
        join
        tally(sb_q.size() == 0 && occ == 0, "R10", "all overlapped words delivered",
              64'(sb_q.size()), 64'd0);
        settle("R10");

        // R9: each threshold preset
        for (int s = 0; s < 4; s++) begin
            do_reset(2'(s));
            for (int k = 0; k < xval; k++) begin fresh(d); wr_word(d, ok); end
            settle("R9");
            fresh(d); wr_word(d, ok);
            settle("R9");
        end

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #3000000;
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL R1 watchdog: actual running expected finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule